// File: doc/BRIEF.md
# Nibble-Configurable Address/IO Port

This block controls one 8-bit bidirectional port of a small microcontroller. The port is split into two 4-bit nibbles. A mode register sets each nibble on its own to one of three uses: general input, general output, or output of high-order external address bits. The lower nibble carries address bits 11..8 and the upper nibble bits 15..12. A system with a 12-bit external space can therefore keep the upper nibble as general I/O.

A global bit selects open-drain drive for general outputs. With open-drain drive, a logic 1 turns the driver off. A bus-float request tri-states every nibble that is carrying address.

An optional handshake mode uses two strobe lines that are borrowed from a neighbouring port: a ready output and an acknowledge input. The transfer direction follows the upper nibble, and the lower nibble is held to the same direction.

A strap selects the reset personality. With the ROMless strap, the port comes out of reset driving address on both nibbles and sets an extended-timing flag for slow memory. Without it, the whole port comes out of reset as input.

Top module: `nibble_port`

## Requirements
- R1: On a reset with `strap_romless`=1, both nibbles are in address mode and `ext_timing`=1. `pin_oe`=8'hFF and `pin_out` equals `addr_hi`.
- R2: On a reset with `strap_romless`=0, both nibbles are input (`pin_oe`=0) and `ext_timing`=0.
- R3: A write with `wr_sel`=1 loads the mode register, and the new setting drives the pins after that clock edge. The register fields are:
  - bits [1:0]: lower-nibble mode
  - bits [3:2]: upper-nibble mode
  - mode codes: 00 = input, 01 = output, 10 = address, 11 = input

  A write with `wr_sel`=0 loads the data register. An output nibble in push-pull drive has all 4 enables set and drives its bits of the data register.
- R4: An address nibble drives its 4 bits of `addr_hi` with all enables set. The lower nibble carries `addr_hi[3:0]` (address 11..8) and the upper nibble `addr_hi[7:4]` (15..12). Each nibble is configured independently, so a lower address nibble and an upper I/O nibble can be mixed.
- R5: While `bus_float`=1, every address nibble has its enables cleared. Input and output nibbles are unaffected.
- R6: Mode bit 4 set selects open-drain drive for output nibbles. A data bit of 1 clears that pin's enable, and a data bit of 0 enables a driven 0. Address nibbles always drive push-pull.
- R7: Mode bit 6 is the extended-timing flag. It follows every mode write, so software can clear it.
- R8: Mode bit 5 enables handshake. When handshake is on and the upper nibble is input or output, the lower-nibble field that is written is replaced by the upper one.
- R9: In handshake output, a data write latches the data and drives `hs_ready` low. `hs_ready` returns high only after `hs_ack` has been seen low and then seen high. A data write in the same cycle as that completion keeps `hs_ready` low.
- R10: In handshake input, the pins are captured on the clock edge that sees `hs_ack` fall. The readback returns the captured byte, and `hs_ready` stays high.
- R11: Readback of the data register, outside handshake input, gives the data register bits for output nibbles and the live pins for input and address nibbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_romless | input | 1 | Reset personality: 1 selects address outputs and extended timing |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 data, 1 mode |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Data register readback |
| addr_hi | input | 8 | External address bits 15..8 |
| bus_float | input | 1 | Request to tri-state address outputs |
| pin_in | input | 8 | Pad input values |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| hs_ack | input | 1 | Handshake acknowledge / input strobe |
| hs_ready | output | 1 | Handshake data-available strobe, active low |
| ext_timing | output | 1 | Extended memory timing flag |

## Verification
The handshake engine can receive a new data write in the same clock cycle in which the acknowledge completes the previous transfer. The bench provokes this by first driving `hs_ack` low. It then raises `hs_ack` and issues a data write at the same falling clock edge, and checks that `hs_ready` is still low one cycle later, because the new transfer must win. A second collision pairs a bus-float request with a mode write that moves a nibble into address mode; the enables are expected to stay cleared after that edge.

// File: rtl/np_pkg.sv
// Package np_pkg: shared nibble-mode type and the decode of the 2-bit
// mode field. Assumes the encoding 00 in, 01 out, 10 address, 11 in.
package np_pkg;
    typedef enum logic [1:0] {
        NM_IN   = 2'b00,
        NM_OUT  = 2'b01,
        NM_ADDR = 2'b10
    } nib_mode_t;

    function automatic nib_mode_t decode_mode(input logic [1:0] code);
        case (code)
            2'b01:   return NM_OUT;
            2'b10:   return NM_ADDR;
            default: return NM_IN;
        endcase
    endfunction
endpackage

// File: rtl/np_mode_reg.sv
// np_mode_reg: holds per-nibble modes, drive type, handshake enable and
// the extended-timing flag. The strap picks the reset values. A write
// with handshake on copies the upper direction onto the lower nibble.
module np_mode_reg
    import np_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      strap_romless,
    input  logic      wr,
    input  logic [7:0] wdata,
    output nib_mode_t mode_lo,
    output nib_mode_t mode_hi,
    output logic      open_drain,
    output logic      hs_en,
    output logic      ext_tmg
);
    nib_mode_t new_hi;
    nib_mode_t new_lo;

    // Decode the incoming fields and apply the handshake direction rule.
    always_comb begin
        new_hi = decode_mode(wdata[3:2]);
        new_lo = decode_mode(wdata[1:0]);
        if (wdata[5] && new_hi != NM_ADDR) begin
            new_lo = new_hi;
        end
    end

    // Register the configuration; the reset values depend on the strap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_lo    <= strap_romless ? NM_ADDR : NM_IN;
            mode_hi    <= strap_romless ? NM_ADDR : NM_IN;
            ext_tmg    <= strap_romless;
            open_drain <= 1'b0;
            hs_en      <= 1'b0;
        end else if (wr) begin
            mode_lo    <= new_lo;
            mode_hi    <= new_hi;
            ext_tmg    <= wdata[6];
            open_drain <= wdata[4];
            hs_en      <= wdata[5];
        end
    end

    assert_hs_dir_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && mode_hi != NM_ADDR) |-> (mode_lo == mode_hi));

    assert_reset_personality_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ext_tmg == $past(strap_romless)));
endmodule

// File: rtl/np_nibble_drv.sv
// np_nibble_drv: combinational pad driver for one nibble. Picks the
// data or address source, and applies open-drain drive and bus float.
// Assumes the enables are sampled by pad logic outside this block.
module np_nibble_drv
    import np_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  nib_mode_t          mode,
    input  logic               open_drain,
    input  logic               bus_float,
    input  logic [NIB_W-1:0]   data,
    input  logic [NIB_W-1:0]   addr,
    output logic [NIB_W-1:0]   out,
    output logic [NIB_W-1:0]   oe
);
    // Select the output value and enable for the current nibble mode.
    always_comb begin
        out = '0;
        oe  = '0;
        case (mode)
            NM_OUT: begin
                if (open_drain) begin
                    out = '0;
                    oe  = ~data;
                end else begin
                    out = data;
                    oe  = '1;
                end
            end
            NM_ADDR: begin
                out = addr;
                oe  = bus_float ? '0 : '1;
            end
            default: begin
                out = '0;
                oe  = '0;
            end
        endcase
    end
endmodule

// File: rtl/np_handshake.sv
// np_handshake: two-wire strobe engine. In output direction a data write
// pulls ready low until ack has been seen low then high. In input
// direction the pins are captured when ack falls. Assumes hs_ack is
// already synchronous to clk.
module np_handshake #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              dir_out,
    input  logic              data_wr,
    input  logic              ack,
    input  logic [PORT_W-1:0] pins,
    output logic              ready,
    output logic [PORT_W-1:0] cap
);
    logic ack_q;
    logic ack_seen_low;
    logic load;
    logic ack_fall;

    assign load     = active && dir_out && data_wr;
    assign ack_fall = ack_q && !ack;

    // Delay ack by one clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b1;
        else        ack_q <= ack;
    end

    // Output-direction ready strobe and acknowledge tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready        <= 1'b1;
            ack_seen_low <= 1'b0;
        end else if (!(active && dir_out)) begin
            ready        <= 1'b1;
            ack_seen_low <= 1'b0;
        end else if (load) begin
            ready        <= 1'b0;
            ack_seen_low <= 1'b0;
        end else if (!ready) begin
            if (!ack)              ack_seen_low <= 1'b1;
            else if (ack_seen_low) ready        <= 1'b1;
        end
    end

    // Input-direction capture on the falling acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                               cap <= '0;
        else if (active && !dir_out && ack_fall)  cap <= pins;
    end

    assert_rdy_fall_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(load));

    assert_rdy_rise_needs_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready) && $past(active && dir_out)) |-> $past(ack));

    assert_rdy_high_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !dir_out && $past(active && !dir_out)) |-> ready);
endmodule

// File: rtl/nibble_port.sv
// nibble_port: 8-bit port with per-nibble input/output/address modes,
// global open-drain option, bus float for address nibbles and an
// optional two-strobe handshake. Register writes land on the next edge.
module nibble_port
    import np_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strap_romless,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [2*NIB_W-1:0]   wr_data,
    output logic [2*NIB_W-1:0]   rd_data,
    input  logic [2*NIB_W-1:0]   addr_hi,
    input  logic                 bus_float,
    input  logic [2*NIB_W-1:0]   pin_in,
    output logic [2*NIB_W-1:0]   pin_out,
    output logic [2*NIB_W-1:0]   pin_oe,
    input  logic                 hs_ack,
    output logic                 hs_ready,
    output logic                 ext_timing
);
    localparam int PORT_W = 2 * NIB_W;
    localparam int NIBS   = 2;

    nib_mode_t           modes [NIBS];
    logic                open_drain;
    logic                hs_en;
    logic [PORT_W-1:0]   data_q;
    logic [PORT_W-1:0]   cap;
    logic                hs_active;
    logic                hs_dir_out;
    logic                data_wr;

    assign data_wr    = wr_en && !wr_sel;
    assign hs_active  = hs_en && (modes[1] != NM_ADDR);
    assign hs_dir_out = (modes[1] == NM_OUT);

    np_mode_reg u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .strap_romless (strap_romless),
        .wr            (wr_en && wr_sel),
        .wdata         (wr_data),
        .mode_lo       (modes[0]),
        .mode_hi       (modes[1]),
        .open_drain    (open_drain),
        .hs_en         (hs_en),
        .ext_tmg       (ext_timing)
    );

    // Output data register.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (data_wr) data_q <= wr_data;
    end

    np_handshake #(.PORT_W(PORT_W)) u_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (hs_active),
        .dir_out (hs_dir_out),
        .data_wr (data_wr),
        .ack     (hs_ack),
        .pins    (pin_in),
        .ready   (hs_ready),
        .cap     (cap)
    );

    for (genvar g = 0; g < NIBS; g++) begin : g_nib
        np_nibble_drv #(.NIB_W(NIB_W)) u_drv (
            .mode       (modes[g]),
            .open_drain (open_drain),
            .bus_float  (bus_float),
            .data       (data_q[g*NIB_W +: NIB_W]),
            .addr       (addr_hi[g*NIB_W +: NIB_W]),
            .out        (pin_out[g*NIB_W +: NIB_W]),
            .oe         (pin_oe[g*NIB_W +: NIB_W])
        );

        // Readback per nibble: captured, latched or live pin value.
        always_comb begin
            if (hs_active && !hs_dir_out)
                rd_data[g*NIB_W +: NIB_W] = cap[g*NIB_W +: NIB_W];
            else if (modes[g] == NM_OUT)
                rd_data[g*NIB_W +: NIB_W] = data_q[g*NIB_W +: NIB_W];
            else
                rd_data[g*NIB_W +: NIB_W] = pin_in[g*NIB_W +: NIB_W];
        end

        assert_float_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_float && modes[g] == NM_ADDR) |-> (pin_oe[g*NIB_W +: NIB_W] == '0));

        assert_od_no_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (open_drain && modes[g] == NM_OUT)
                |-> ((pin_out[g*NIB_W +: NIB_W] & pin_oe[g*NIB_W +: NIB_W]) == '0));
    end
endmodule

// File: tb/test_nibble_port.sv
// Bench for nibble_port: directed corner cases plus seeded random mode,
// data, address, pin and float patterns against a bench-side model.
module test_nibble_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_romless = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [7:0] addr_hi = 8'h00;
    logic       bus_float = 1'b0;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       hs_ack = 1'b1;
    logic       hs_ready;
    logic       ext_timing;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    nibble_port i_nibble_port (
        .clk(clk), .rst_n(rst_n), .strap_romless(strap_romless),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_data(rd_data),
        .addr_hi(addr_hi), .bus_float(bus_float), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .hs_ack(hs_ack),
        .hs_ready(hs_ready), .ext_timing(ext_timing)
    );

    // bench model state: mode codes per R3 (0 in, 1 out, 2 addr)
    int  m_lo, m_hi;
    bit  m_od, m_ext;
    logic [7:0] m_data;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int dec(input logic [1:0] c);
        return (c == 2'b01) ? 1 : (c == 2'b10) ? 2 : 0;
    endfunction

    // expected enables for one nibble
    function automatic logic [3:0] exp_oe(input int m, input bit od, input bit fl, input logic [3:0] d);
        if (m == 1) return od ? ~d : 4'hF;
        if (m == 2) return fl ? 4'h0 : 4'hF;
        return 4'h0;
    endfunction

    // expected driven values (only meaningful where enabled)
    function automatic logic [3:0] exp_out(input int m, input bit od, input logic [3:0] d, input logic [3:0] a);
        if (m == 1) return od ? 4'h0 : d;
        if (m == 2) return a;
        return 4'h0;
    endfunction

    function automatic logic [3:0] exp_rd(input int m, input logic [3:0] d, input logic [3:0] p);
        return (m == 1) ? d : p;
    endfunction

    task automatic do_write(input bit sel, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = v;
        @(posedge clk); #1;
        wr_en = 1'b0;
        if (sel) begin
            m_hi = dec(v[3:2]); m_lo = dec(v[1:0]);
            if (v[5] && m_hi != 2) m_lo = m_hi;
            m_od = v[4]; m_ext = v[6];
        end else begin
            m_data = v;
        end
    endtask

    task automatic do_reset(input bit strap);
        @(negedge clk);
        rst_n = 1'b0; strap_romless = strap;
        @(posedge clk); #1;
        @(negedge clk);
        rst_n = 1'b1;
        m_data = '0; m_od = 0; m_ext = strap;
        m_lo = strap ? 2 : 0; m_hi = m_lo;
        #1;
    endtask

    task automatic check_port(input string req);
        logic [7:0] eoe, eout, erd;
        eoe  = {exp_oe(m_hi, m_od, bus_float, m_data[7:4]), exp_oe(m_lo, m_od, bus_float, m_data[3:0])};
        eout = {exp_out(m_hi, m_od, m_data[7:4], addr_hi[7:4]), exp_out(m_lo, m_od, m_data[3:0], addr_hi[3:0])};
        erd  = {exp_rd(m_hi, m_data[7:4], pin_in[7:4]), exp_rd(m_lo, m_data[3:0], pin_in[3:0])};
        check({req, " oe"}, pin_oe, eoe);
        check({req, " out"}, pin_out & pin_oe, eout & eoe);
        check({req, " rd (R11)"}, rd_data, erd);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        int seed;
        logic [7:0] v;
        seed = 32'h5EED_0017;
        v = $urandom(seed);
        addr_hi = 8'hC3; pin_in = 8'h5A;
        repeat (3) @(posedge clk);

        // R1: ROMless reset
        do_reset(1'b1);
        check("R1 oe", pin_oe, 8'hFF);
        check("R1 out", pin_out, 8'hC3);
        check("R1 ext", ext_timing, 1);
        check("R1 ready", hs_ready, 1);
        // R5: float address nibbles
        bus_float = 1'b1; #1;
        check("R5 float", pin_oe, 8'h00);
        bus_float = 1'b0; #1;
        // R7: clear extended timing; R4: lower address, upper output
        do_write(1'b0, 8'h9E);
        do_write(1'b1, 8'h06);
        check("R7 ext cleared", ext_timing, 0);
        check_port("R4 mixed");
        check("R4 pins", pin_out, 8'h93);
        bus_float = 1'b1; #1;
        check("R5 io unaffected", pin_oe, 8'hF0);
        bus_float = 1'b0;
        do_write(1'b1, 8'h40);
        check("R7 ext set", ext_timing, 1);
        // R6: open drain, both outputs
        do_write(1'b1, 8'h15);
        check("R6 oe", pin_oe, 8'h61);
        check("R6 out", pin_out & pin_oe, 8'h00);
        // R3: code 11 is input
        do_write(1'b1, 8'h0F);
        check("R3 code11", pin_oe, 8'h00);

        // R2: ROM reset
        do_reset(1'b0);
        check("R2 oe", pin_oe, 8'h00);
        check("R2 ext", ext_timing, 0);

        // R8: handshake forcing, upper out lower in
        do_write(1'b1, 8'h24);
        do_write(1'b0, 8'hA5);
        check("R8 forced lower out", pin_oe, 8'hFF);
        check("R9 data", pin_out, 8'hA5);
        check("R9 ready low", hs_ready, 0);
        repeat (3) @(posedge clk); #1;
        check("R9 ack high only", hs_ready, 0);
        @(negedge clk); hs_ack = 1'b0;
        @(posedge clk); #1;
        check("R9 ack low", hs_ready, 0);
        @(negedge clk); hs_ack = 1'b1;
        @(posedge clk); #1;
        check("R9 ack complete", hs_ready, 1);
        // R9 collision: write coincides with ack completion
        do_write(1'b0, 8'h3C);
        @(negedge clk); hs_ack = 1'b0;
        @(posedge clk); #1;
        @(negedge clk); hs_ack = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h77;
        @(posedge clk); #1;
        wr_en = 1'b0; m_data = 8'h77;
        check("R9 collision ready", hs_ready, 0);
        check("R9 collision data", pin_out, 8'h77);

        // R10: handshake input, upper in lower out -> forced input
        do_write(1'b1, 8'h21);
        check("R8 forced lower in", pin_oe, 8'h00);
        pin_in = 8'h3C;
        @(negedge clk); hs_ack = 1'b0;
        @(posedge clk); #1;
        @(negedge clk); pin_in = 8'h00; hs_ack = 1'b1; #1;
        check("R10 capture", rd_data, 8'h3C);
        check("R10 ready", hs_ready, 1);

        // R5 collision: float together with a mode write into address
        do_write(1'b1, 8'h00);
        @(negedge clk); bus_float = 1'b1; wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h0A;
        @(posedge clk); #1;
        wr_en = 1'b0; m_hi = 2; m_lo = 2; m_od = 0; m_ext = 0;
        check("R5 float+mode", pin_oe, 8'h00);
        bus_float = 1'b0;

        // random: R3 R4 R5 R6 R7 R11
        for (int i = 0; i < 300; i++) begin
            v = $urandom;
            do_write(1'b1, v & 8'hDF);
            do_write(1'b0, $urandom);
            @(negedge clk);
            addr_hi = $urandom; pin_in = $urandom; bus_float = $urandom;
            #1;
            check_port("R3 random");
            check("R7 random ext", ext_timing, m_ext);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule